// File: doc/BRIEF.md
# Undervoltage and Thermal Fault Supervisor

This block merges the results of the undervoltage comparators and a digital die-temperature code into two outputs. The first is a fault indication, which is a flag only. The second is a latched thermal kill that switches off every power output. Each undervoltage comparator flag is counted only when two conditions hold: the plane it watches is enabled, and the soft-start sequencer has declared monitoring active. A counted flag must then stay high for a full reporting delay before it reaches the fault output.

An undervoltage never turns anything off. It only raises the fault output, and the fault drops again once the cause is gone. Temperature has two levels. The warning level raises the fault output while the outputs keep running. The kill level sets a latch that holds the outputs off. Only a power-on reset clears that latch. A shutdown input holds the fault output low, except while the thermal latch is set, because the latch overrides everything.

The power-on reset is asynchronous and active low, and it is released synchronously inside the block. All timing in the requirements counts rising clock edges after that release.

Top module: `fault_supervisor`

## Requirements
- R1: After reset both `fault` and `therm_kill` are 0.
- R2: A UV flag is ignored, so `fault` stays 0, when its `plane_en` bit is 0 or when `mon_en` is 0, however long the flag is held.
- R3: Plane i counts as qualified when `uv_flag[i]`, `plane_en[i]` and `mon_en` are all 1. Take the first edge that samples it qualified as edge 1. If qualification holds, `fault` is still 0 after edge UV_DELAY and becomes 1 after edge UV_DELAY+1. If qualification is lost before edge UV_DELAY+1, `fault` does not rise.
- R4: An undervoltage never sets `therm_kill`.
- R5: When no plane is qualified any more, or `temp_code` falls below WARN_C, `fault` returns to 0 one edge later, provided no other cause remains.
- R6: While `shutdown` is 1 and the thermal latch is clear, `fault` is 0 one edge after `shutdown` is sampled. When `shutdown` is released, a pending cause raises `fault` again one edge later.
- R7: If `temp_code` (unsigned, in °C) is at least WARN_C (default 125), `fault` is 1 one edge later and `therm_kill` stays 0. A code of WARN_C-1 raises nothing.
- R8: If `temp_code` is at least KILL_C (default 150), `therm_kill` is 1 one edge later. It stays 1 whatever the temperature does afterwards, and only `rst_n` low clears it. A code of KILL_C-1 does not set it.
- R9: While `therm_kill` is 1, `fault` is 1, even when `shutdown` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| uv_flag | input | N_PLANES | Undervoltage comparator result for each plane |
| plane_en | input | N_PLANES | Enable for each plane, from the state logic |
| mon_en | input | 1 | Monitoring-active signal from the soft-start sequencer |
| shutdown | input | 1 | Shutdown request; holds the fault output low |
| temp_code | input | 8 | Die temperature in °C, unsigned |
| fault | output | 1 | Combined fault indication |
| therm_kill | output | 1 | Latched over-temperature kill for all outputs |

## Verification
The bench probes the edges of the reporting delay. A flag held for exactly UV_DELAY edges and then dropped must leave `fault` low. A design that is one count short would flag that glitch, and one that is one count long would report late. Each temperature threshold is checked one code below it and exactly at it, which catches a `>` written where `>=` was meant. After a kill, the temperature is brought back down and shutdown is asserted, to show that the latch neither follows the temperature nor yields to shutdown. A design that cleared the fault on shutdown during a kill, or that let the latch drop when the die cooled, fails there. UV flags are also held on disabled planes and with monitoring off, to catch a qualifier that leaves out one of its terms.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  parameter int unsigned TEMP_W = 8;
  typedef logic [TEMP_W-1:0] temp_t;
endpackage

// File: rtl/fsup_rst_sync.sv
module fsup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/fsup_uv_qual.sv
module fsup_uv_qual #(
  parameter int unsigned UV_DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(UV_DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(UV_DELAY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);

  always_comb begin
    if (!qual_i)       cnt_d = '0;
    else if (at_limit) cnt_d = cnt_q;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Report only while still qualified so loss of the flag clears in one edge.
  assign hit_o = qual_i & at_limit;
endmodule

// File: rtl/fsup_thermal.sv
module fsup_thermal
  import fsup_pkg::*;
#(
  parameter temp_t WARN_C = 8'd125,
  parameter temp_t KILL_C = 8'd150
) (
  input  logic  clk,
  input  logic  rst_n,
  input  temp_t temp_i,
  output logic  warn_o,
  output logic  kill_now_o,
  output logic  kill_o
);
  logic kill_q, kill_d;

  assign warn_o     = (temp_i >= WARN_C);
  assign kill_now_o = (temp_i >= KILL_C);

  always_comb begin
    kill_d = kill_q | kill_now_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= kill_d;
  end

  assign kill_o = kill_q;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned N_PLANES = 3,
  parameter int unsigned UV_DELAY = 1000,
  parameter temp_t       WARN_C   = 8'd125,
  parameter temp_t       KILL_C   = 8'd150
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PLANES-1:0] uv_flag,
  input  logic [N_PLANES-1:0] plane_en,
  input  logic                mon_en,
  input  logic                shutdown,
  input  logic [TEMP_W-1:0]   temp_code,
  output logic                fault,
  output logic                therm_kill
);
  logic                rst_sn;
  logic [N_PLANES-1:0] uv_hit;
  logic                warn, kill_now, kill_q;
  logic                fault_q, fault_d;

  fsup_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  for (genvar i = 0; i < N_PLANES; i++) begin : g_plane
    fsup_uv_qual #(.UV_DELAY(UV_DELAY)) u_qual (
      .clk    (clk),
      .rst_n  (rst_sn),
      .qual_i (uv_flag[i] & plane_en[i] & mon_en),
      .hit_o  (uv_hit[i])
    );
  end

  fsup_thermal #(.WARN_C(WARN_C), .KILL_C(KILL_C)) u_therm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .temp_i     (temp_code),
    .warn_o     (warn),
    .kill_now_o (kill_now),
    .kill_o     (kill_q)
  );

  always_comb begin
    if (kill_q || kill_now) fault_d = 1'b1;
    else if (shutdown)      fault_d = 1'b0;
    else                    fault_d = (|uv_hit) | warn;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) fault_q <= 1'b0;
    else         fault_q <= fault_d;
  end

  assign fault      = fault_q;
  assign therm_kill = kill_q;
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk
  import fsup_pkg::*;
#(
  parameter temp_t WARN_C = 8'd125,
  parameter temp_t KILL_C = 8'd150
) (
  input logic        clk,
  input logic        rst_sn,
  input logic        mon_en,
  input logic        shutdown,
  input logic [7:0]  temp_code,
  input logic        fault,
  input logic        therm_kill
);
  AST_KILL_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    therm_kill |=> therm_kill); // R8

  AST_KILL_SET: assert property (@(posedge clk) disable iff (!rst_sn)
    (temp_code >= KILL_C) |=> therm_kill); // R8

  AST_KILL_FAULT: assert property (@(posedge clk) disable iff (!rst_sn)
    therm_kill |-> fault); // R9

  AST_WARN_FAULT: assert property (@(posedge clk) disable iff (!rst_sn)
    ((temp_code >= WARN_C) && !shutdown) |=> fault); // R7

  AST_SD_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    (shutdown && !therm_kill && (temp_code < KILL_C)) |=> !fault); // R6

  AST_NO_MON: assert property (@(posedge clk) disable iff (!rst_sn)
    (!mon_en && $past(!mon_en) && (temp_code < WARN_C) && !therm_kill) |=> !fault); // R2
endmodule

bind fault_supervisor fault_supervisor_chk #(.WARN_C(WARN_C), .KILL_C(KILL_C)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .mon_en     (mon_en),
  .shutdown   (shutdown),
  .temp_code  (temp_code),
  .fault      (fault),
  .therm_kill (therm_kill)
);

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;
  localparam int D = 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] uv_flag, plane_en;
  logic       mon_en, shutdown;
  logic [7:0] temp_code;
  logic       fault, therm_kill;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fault_supervisor #(.N_PLANES(3), .UV_DELAY(D), .WARN_C(8'd125), .KILL_C(8'd150)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .plane_en(plane_en),
    .mon_en(mon_en), .shutdown(shutdown), .temp_code(temp_code),
    .fault(fault), .therm_kill(therm_kill)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Advance n rising edges, then settle just past the edge.
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; uv_flag = '0; plane_en = '0; mon_en = 1'b0;
    shutdown = 1'b0; temp_code = 8'd40;
    edges(2);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 fault after reset", fault, 1'b0);
    chk("R1 therm_kill after reset", therm_kill, 1'b0);
  endtask

  task automatic t_uv_timing();
    @(negedge clk);
    plane_en = 3'b111; mon_en = 1'b1; uv_flag = 3'b010;
    edges(D);
    chk("R3 fault low at edge UV_DELAY", fault, 1'b0);
    edges(1);
    chk("R3 fault high at edge UV_DELAY+1", fault, 1'b1);
    chk("R4 uv does not kill", therm_kill, 1'b0);
    @(negedge clk);
    uv_flag = 3'b000;
    edges(1);
    chk("R5 fault clears one edge after uv drops", fault, 1'b0);
    // glitch of exactly UV_DELAY qualified edges
    @(negedge clk);
    uv_flag = 3'b100;
    edges(D);
    @(negedge clk);
    uv_flag = 3'b000;
    edges(4);
    chk("R3 short uv pulse ignored", fault, 1'b0);
  endtask

  task automatic t_qualify();
    @(negedge clk);
    uv_flag = 3'b111; plane_en = 3'b000; mon_en = 1'b1;
    edges(D + 20);
    chk("R2 uv on disabled planes ignored", fault, 1'b0);
    @(negedge clk);
    uv_flag = 3'b000;
    edges(2);
    @(negedge clk);
    uv_flag = 3'b111; plane_en = 3'b111; mon_en = 1'b0;
    edges(D + 20);
    chk("R2 uv with monitoring off ignored", fault, 1'b0);
    @(negedge clk);
    uv_flag = 3'b000; mon_en = 1'b1;
    edges(2);
  endtask

  task automatic t_shutdown();
    @(negedge clk);
    uv_flag = 3'b001;
    edges(D + 1);
    chk("R3 fault before shutdown", fault, 1'b1);
    @(negedge clk);
    shutdown = 1'b1;
    edges(1);
    chk("R6 shutdown forces fault low", fault, 1'b0);
    @(negedge clk);
    shutdown = 1'b0;
    edges(1);
    chk("R6 fault returns after shutdown release", fault, 1'b1);
    @(negedge clk);
    uv_flag = 3'b000;
    edges(1);
    chk("R5 fault clears after uv removed", fault, 1'b0);
  endtask

  task automatic t_warn();
    @(negedge clk);
    temp_code = 8'd124;
    edges(3);
    chk("R7 124 C raises no fault", fault, 1'b0);
    @(negedge clk);
    temp_code = 8'd125;
    edges(1);
    chk("R7 125 C raises fault", fault, 1'b1);
    chk("R7 125 C no kill", therm_kill, 1'b0);
    @(negedge clk);
    temp_code = 8'd149;
    edges(3);
    chk("R8 149 C no kill", therm_kill, 1'b0);
    @(negedge clk);
    temp_code = 8'd100;
    edges(1);
    chk("R5 fault clears when cooled", fault, 1'b0);
  endtask

  task automatic t_kill();
    @(negedge clk);
    temp_code = 8'd150;
    edges(1);
    chk("R8 150 C sets kill", therm_kill, 1'b1);
    chk("R9 kill gives fault", fault, 1'b1);
    @(negedge clk);
    temp_code = 8'd25;
    edges(5);
    chk("R8 kill holds after cooling", therm_kill, 1'b1);
    @(negedge clk);
    shutdown = 1'b1;
    edges(2);
    chk("R9 fault holds during shutdown", fault, 1'b1);
    @(negedge clk);
    shutdown = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 reset clears kill", therm_kill, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);
    chk("R8 kill clear after reset release", therm_kill, 1'b0);
    chk("R1 fault clear after reset release", fault, 1'b0);
  endtask

  initial begin
    t_reset();
    t_uv_timing();
    t_qualify();
    t_shutdown();
    t_warn();
    t_kill();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule